// File: doc/BRIEF.md
# Normalizing Run-Skipping Binary Fraction Divider

This block divides a 2W-bit dividend by a W-bit divisor. Both are read as binary fractions. It is sequential. On an accepted start it shifts the divisor left until its top bit is set, so that 0.5 <= B < 1. It shifts the combined remainder/quotient register left by the same distance, which leaves the ratio unchanged.

The iteration phase then works on a signed partial remainder. While the partial remainder is non-negative and begins with a run of zeros, or negative and begins with a run of ones, the whole usable run is consumed in a single cycle. Each position shifted over pushes one quotient bit into the low end of the quotient register: a 0 for a run of zeros, a 1 for a run of ones. When no run is available, a single subtract of B (non-negative remainder) or add of B (negative remainder) is done, with a one-position shift. That step yields one quotient bit, set when the new remainder is non-negative. A counter stops the iteration after exactly W quotient bits. A negative final remainder is then corrected by adding B back, and it is scaled back to the caller's scale.

A host pulses start while the block is idle. It reads the quotient, the remainder and the zero-divisor flag in the cycle where done is high. The results stay unchanged until the next accepted start. Results are defined when the upper half of the dividend is below the divisor, so that the quotient fits in W bits.

Top module: `runskip_div`

## Requirements
- R1: After reset, busy_o, done_o and div_zero_o are 0, and quot_o and rem_o are all zeros.
- R2: A start_i sampled high while busy_o is low is accepted, and busy_o is high from the next cycle. busy_o stays high through the cycle in which done_o is high. done_o is high for exactly one cycle per accepted start.
- R3: With a non-zero divisor and dividend[2W-1:W] < divisor, quot_o at done equals floor(dividend / divisor).
- R4: Under the same conditions, rem_o at done equals dividend mod divisor, in the unscaled units of the inputs, and is therefore below the divisor.
- R5: A zero divisor sets div_zero_o to 1 with quot_o = 0 and rem_o = 0. done_o rises on the first clock edge after acceptance. The flag is cleared by the next accepted start that has a non-zero divisor.
- R6: done_o rises no later than W+2 clock edges after the accepting edge, counting the accepting edge as the first. A zero dividend with a non-zero divisor finishes on the 4th edge, because runs of skipped positions are consumed several per cycle.
- R7: A start_i raised while busy_o is high is ignored: the running operation finishes with results computed from its own operands.
- R8: While idle, quot_o, rem_o and div_zero_o hold the values of the last completed operation.
- R9: A divisor with any number of leading zero bits, down to a value of 1, produces the results of R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only while idle |
| divisor_i | input | W | Divisor fraction |
| dividend_i | input | 2W | Dividend fraction, upper half in A, lower half in Q |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe, results valid |
| quot_o | output | W | Quotient |
| rem_o | output | W | Remainder, in input scale |
| div_zero_o | output | 1 | Last operation had a zero divisor |

## Verification
Two situations are hardest to reach from the ports. The first is a run of ones in a negative partial remainder that is cut short by the bit counter, leaving a negative remainder that the final correction must repair. The second is a run long enough to be capped by the number of quotient bits still owed. The stimulus reaches them with directed operand pairs: tiny divisors with near-maximal upper dividends, divisors just above one half, a zero dividend, and a divisor of 1 that forces the widest normalization. Several hundred random in-range operand pairs follow. A reference model in the bench checks every clock, and a queue of expected results is popped at each done strobe.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2,
    ST_DONE = 2'd3
  } rsd_state_e;
endpackage

// File: rtl/rsd_norm.sv
module rsd_norm #(
  parameter int W  = 8,
  parameter int SW = 3
) (
  input  logic [W-1:0]   dsr_i,
  input  logic [2*W-1:0] dnd_i,
  output logic [W-1:0]   dsr_o,
  output logic [2*W-1:0] dnd_o,
  output logic [SW-1:0]  lz_o
);
  logic [SW-1:0] lz;
  logic          hit;

  // leading zero count; a zero divisor is trapped upstream
  always_comb begin
    lz  = '0;
    hit = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit) begin
        if (dsr_i[i]) hit = 1'b1;
        else          lz  = lz + SW'(1);
      end
    end
  end

  assign dsr_o = dsr_i << lz;
  assign dnd_o = dnd_i << lz;
  assign lz_o  = lz;
endmodule

// File: rtl/rsd_run_det.sv
module rsd_run_det #(
  parameter int W  = 8,
  parameter int CW = 4,
  parameter int SW = 3
) (
  input  logic [W:0]    par_i,
  input  logic [CW-1:0] left_i,
  output logic [SW-1:0] skip_o
);
  int   run;
  int   sk;
  logic same;

  // s skips are legal when par[W:W-1-s] all match the sign
  always_comb begin
    run  = 0;
    same = 1'b1;
    for (int i = W - 1; i >= 0; i--) begin
      if (same && (par_i[i] == par_i[W])) run = run + 1;
      else                                same = 1'b0;
    end
    sk = (run > 0) ? run - 1 : 0;
    if (sk > int'(left_i)) sk = int'(left_i);
    skip_o = SW'(sk);
  end
endmodule

// File: rtl/rsd_step.sv
module rsd_step #(
  parameter int W  = 8,
  parameter int SW = 3
) (
  input  logic [W:0]    par_i,
  input  logic [W-1:0]  quo_i,
  input  logic [W-1:0]  dsr_i,
  input  logic [SW-1:0] skip_i,
  output logic [W:0]    par_o,
  output logic [W-1:0]  quo_o
);
  logic [2*W:0]  cat_sh;
  logic [W-1:0]  fill;
  logic [W+1:0]  dbl;
  logic [W+1:0]  sum;

  always_comb begin
    cat_sh = {par_i, quo_i} << skip_i;
    fill   = {W{par_i[W]}} & ((W'(1) << skip_i) - W'(1));
    dbl    = {par_i[W], par_i, quo_i[W-1]};
    sum    = par_i[W] ? dbl + {2'b00, dsr_i} : dbl - {2'b00, dsr_i};
    if (skip_i != '0) begin
      par_o = cat_sh[2*W:W];
      quo_o = cat_sh[W-1:0] | fill;
    end else begin
      par_o = sum[W:0];
      quo_o = {quo_i[W-2:0], ~sum[W]};
    end
  end
endmodule

// File: rtl/runskip_div.sv
module runskip_div
  import rsd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [W-1:0]   divisor_i,
  input  logic [2*W-1:0] dividend_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [W-1:0]   quot_o,
  output logic [W-1:0]   rem_o,
  output logic           div_zero_o
);
  localparam int CW = $clog2(W + 1);
  localparam int SW = $clog2(W);

  rsd_state_e    state_q;
  logic [W:0]    par_q;
  logic [W-1:0]  quo_q;
  logic [W-1:0]  dsr_q;
  logic [SW-1:0] shf_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  res_quo_q;
  logic [W-1:0]  res_rem_q;
  logic          dz_q;

  logic [W-1:0]   n_dsr;
  logic [2*W-1:0] n_dnd;
  logic [SW-1:0]  n_lz;
  logic [SW-1:0]  skip;
  logic [CW-1:0]  left;
  logic [CW-1:0]  step_n;
  logic [CW-1:0]  cnt_nx;
  logic [W:0]     par_nx;
  logic [W-1:0]   quo_nx;
  logic [W:0]     par_fix;

  rsd_norm #(.W(W), .SW(SW)) u_norm (
    .dsr_i (divisor_i),
    .dnd_i (dividend_i),
    .dsr_o (n_dsr),
    .dnd_o (n_dnd),
    .lz_o  (n_lz)
  );

  rsd_run_det #(.W(W), .CW(CW), .SW(SW)) u_run (
    .par_i  (par_q),
    .left_i (left),
    .skip_o (skip)
  );

  rsd_step #(.W(W), .SW(SW)) u_step (
    .par_i  (par_q),
    .quo_i  (quo_q),
    .dsr_i  (dsr_q),
    .skip_i (skip),
    .par_o  (par_nx),
    .quo_o  (quo_nx)
  );

  assign left    = CW'(W) - cnt_q;
  assign step_n  = (skip == '0) ? CW'(1) : CW'(skip);
  assign cnt_nx  = cnt_q + step_n;
  assign par_fix = par_q[W] ? par_q + {1'b0, dsr_q} : par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      par_q     <= '0;
      quo_q     <= '0;
      dsr_q     <= '0;
      shf_q     <= '0;
      cnt_q     <= '0;
      res_quo_q <= '0;
      res_rem_q <= '0;
      dz_q      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (divisor_i == '0) begin
              dz_q      <= 1'b1;
              res_quo_q <= '0;
              res_rem_q <= '0;
              state_q   <= ST_DONE;
            end else begin
              dz_q    <= 1'b0;
              dsr_q   <= n_dsr;
              par_q   <= {1'b0, n_dnd[2*W-1:W]};
              quo_q   <= n_dnd[W-1:0];
              shf_q   <= n_lz;
              cnt_q   <= '0;
              state_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          par_q <= par_nx;
          quo_q <= quo_nx;
          cnt_q <= cnt_nx;
          if (cnt_nx == CW'(W)) state_q <= ST_FIX;
        end
        ST_FIX: begin
          res_quo_q <= quo_q;
          res_rem_q <= par_fix[W-1:0] >> shf_q;
          state_q   <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign quot_o     = res_quo_q;
  assign rem_o      = res_rem_q;
  assign div_zero_o = dz_q;
endmodule

// File: rtl/rsd_chk.sv
module rsd_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [W-1:0] divisor_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] quot_o,
  input logic [W-1:0] rem_o,
  input logic         div_zero_o
);
  localparam int LW = $clog2(W + 4) + 1;

  logic [W-1:0]  dsr_cap;
  logic [LW-1:0] lat_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dsr_cap <= '0;
      lat_cnt <= '0;
    end else if (start_i && !busy_o) begin
      dsr_cap <= divisor_i;
      lat_cnt <= LW'(1);
    end else if (busy_o && (lat_cnt != '1)) begin
      lat_cnt <= lat_cnt + LW'(1);
    end
  end

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  assert_rem_below_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !div_zero_o |-> rem_o < dsr_cap);

  assert_zero_div_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && (divisor_i == '0) |=>
      done_o && div_zero_o && (quot_o == '0) && (rem_o == '0));

  assert_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> lat_cnt <= LW'(W + 2));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !$past(busy_o) && !$past(start_i) |->
      $stable(quot_o) && $stable(rem_o) && $stable(div_zero_o));
endmodule

bind runskip_div rsd_chk #(.W(W)) u_rsd_chk (.*);

// File: tb/runskip_div_bench.sv
module runskip_div_bench;
  localparam int W          = 8;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    longint q;
    longint r;
    bit     dz;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   divisor = '0;
  logic [2*W-1:0] dividend = '0;
  logic           busy, done, dz;
  logic [W-1:0]   quot, rem;

  int   n_tests = 0;
  int   n_fail  = 0;
  int   cycles  = 0;
  bit   ended   = 1'b0;
  exp_t expq[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  runskip_div #(.W(W)) u_runskip_div (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .divisor_i  (divisor),
    .dividend_i (dividend),
    .busy_o     (busy),
    .done_o     (done),
    .quot_o     (quot),
    .rem_o      (rem),
    .div_zero_o (dz)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // per-clock model: done implies busy, idle outputs hold (R2, R8)
  logic [W-1:0] p_quot, p_rem;
  logic         p_dz, p_busy, p_start;
  bit           p_valid = 1'b0;
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (done) chk(busy, "R2 done_without_busy", longint'(busy), 1);
      if (p_valid && !busy && !p_busy && !p_start) begin
        chk(quot == p_quot && rem == p_rem && dz == p_dz, "R8 idle_hold",
            longint'(quot), longint'(p_quot));
      end
      p_quot = quot; p_rem = rem; p_dz = dz; p_busy = busy; p_start = start;
      p_valid = 1'b1;
    end
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  // exp_lat == 0: only the R6 bound applies
  task automatic run_op(input logic [W-1:0] dv, input logic [2*W-1:0] dd,
                        input int exp_lat, input bit poke, input string req);
    exp_t e;
    int   lat;
    int   dones;
    e.dz = (dv == '0);
    e.q  = e.dz ? 0 : longint'(dd) / longint'(dv);
    e.r  = e.dz ? 0 : longint'(dd) % longint'(dv);
    @(negedge clk);
    chk(!busy, "R2 idle_before_start", longint'(busy), 0);
    divisor = dv; dividend = dd; start = 1'b1;
    expq.push_back(e);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    dones = 0;
    chk(busy, "R2 busy_after_accept", longint'(busy), 1);
    if (poke && !done) begin
      divisor = W'(3); dividend = (2*W)'(5); start = 1'b1;  // R7: must be ignored
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    chk(done, "R2 done_seen", longint'(done), 1);
    e = expq.pop_front();
    chk(longint'(quot) == e.q, {req, " R3 quotient"}, longint'(quot), e.q);
    chk(longint'(rem) == e.r, {req, " R4 remainder"}, longint'(rem), e.r);
    chk(dz == e.dz, {req, " R5 zero_flag"}, longint'(dz), longint'(e.dz));
    if (exp_lat > 0) chk(lat == exp_lat, {req, " R6 latency_exact"}, lat, exp_lat);
    else             chk(lat <= W + 2, {req, " R6 latency_bound"}, lat, W + 2);
    @(negedge clk);
    chk(!done && !busy, "R2 single_done_pulse", longint'(done), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    // R1 reset state, sampled during reset
    chk(!busy && !done && !dz, "R1 reset_flags", longint'({busy, done, dz}), 0);
    chk(quot == '0 && rem == '0, "R1 reset_data", longint'(quot), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_op(8'h00, 16'h1234, 1, 1'b0, "R5");
    run_op(8'h9A, 16'h0000, 4, 1'b0, "R6 zero_dividend");
    chk(!dz, "R5 flag_cleared", longint'(dz), 0);
    run_op(8'h01, 16'h00B7, 0, 1'b0, "R9 divisor_one");
    run_op(8'h02, 16'h0001, 0, 1'b0, "R9 divisor_two");
    run_op(8'hFF, 16'hFEFF, 0, 1'b0, "R3 max_quotient");
    run_op(8'h80, 16'h7FFF, 0, 1'b0, "R3 half_divisor");
    run_op(8'h03, 16'h02FF, 0, 1'b0, "R4 ones_run");
    run_op(8'h81, 16'h8000, 0, 1'b0, "R4 neg_final");
    run_op(8'hC3, 16'h5A5A, 0, 1'b1, "R7 start_while_busy");
    run_op(8'h00, 16'hFFFF, 1, 1'b0, "R5 second_zero");

    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] dv;
      logic [W-1:0] hi;
      logic [W-1:0] lo;
      dv = W'($urandom_range(1, (1 << W) - 1));
      if (i % 4 == 0) dv = W'(1) << (i % W);
      hi = W'($urandom_range(0, int'(dv) - 1));
      lo = W'($urandom);
      if (i % 5 == 0) lo = '1;
      if (i % 7 == 0) lo = '0;
      run_op(dv, {hi, lo}, 0, 1'b0, (i % 4 == 0) ? "R9 random" : "R3 random");
    end

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule